// File: doc/BRIEF.md
# OSD Overlay Video Mixer

This block merges a coarse on-screen-display layer, generated by an external microcontroller, into a full-rate 8-bit-per-channel RGB pixel stream. The controller supplies three colour-select bits, an overlay-enable bit and a dim bit. The mixer produces a clock at half the pixel rate for that controller and captures the five controller bits into registers once per period of that clock. Because of this, every controller sample covers two adjacent output pixels.

Where overlay is active, one of eight fixed colour-bar colours replaces the incoming pixel. Where only dim is active, the incoming pixel is passed at half intensity so that the overlay text stands out. Horizontal and vertical sync are returned to the controller one clock after they arrive. The mixed pixel and its sync leave the block two pixel clocks after the video enters it.

Top module: `osd_video_mixer`

## Requirements
- R1: While `rst_n` is low, every output is 0, including `ctl_clk`, whatever the inputs are.
- R2: After reset is released, `ctl_clk` changes on every rising `clk` edge. It becomes 1 at the first edge.
- R3: The five controller inputs are captured only at the `clk` edges where `ctl_clk` goes from 0 to 1. Their values at the other edges have no effect. Each captured sample therefore governs exactly two consecutive output pixels.
- R4: When the governing sample has overlay=0 and dim=0, the output pixel equals the video pixel presented two `clk` edges earlier. `out_hsync` and `out_vsync` carry the same two-edge delay.
- R5: When the governing sample has overlay=1, each output channel is 0xBF if its colour-select bit is 1 and 0x40 if it is 0. `osd_red` selects the red channel, `osd_grn` the green channel and `osd_blu` the blue channel. For example, 111 gives BF/BF/BF and 000 gives 40/40/40.
- R6: When the governing sample has dim=1 and overlay=0, each output channel is the delayed video channel shifted right by one bit. For example, 0xFF becomes 0x7F and 0x01 becomes 0x00.
- R7: When both overlay and dim are 1, the overlay colour of R5 is output unchanged.
- R8: `ctl_hsync` and `ctl_vsync` equal `vid_hsync` and `vid_vsync` as sampled at the previous `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_red | input | 8 | Incoming video red channel |
| vid_grn | input | 8 | Incoming video green channel |
| vid_blu | input | 8 | Incoming video blue channel |
| vid_hsync | input | 1 | Incoming horizontal sync |
| vid_vsync | input | 1 | Incoming vertical sync |
| osd_red | input | 1 | Controller red colour-select bit |
| osd_grn | input | 1 | Controller green colour-select bit |
| osd_blu | input | 1 | Controller blue colour-select bit |
| osd_ovl | input | 1 | Controller overlay enable |
| osd_dim | input | 1 | Controller half-intensity request for the background |
| out_red | output | 8 | Mixed red channel |
| out_grn | output | 8 | Mixed green channel |
| out_blu | output | 8 | Mixed blue channel |
| out_hsync | output | 1 | Horizontal sync aligned with the mixed pixel |
| out_vsync | output | 1 | Vertical sync aligned with the mixed pixel |
| ctl_hsync | output | 1 | Horizontal sync returned to the controller |
| ctl_vsync | output | 1 | Vertical sync returned to the controller |
| ctl_clk | output | 1 | Half-rate clock for the controller |

## Verification
The hardest case to reach from the ports is a controller input that changes between two capture edges. The block must ignore that change and keep showing the earlier sample for the second pixel of the pair. The directed stimulus aligns itself to the capture phase. It then sets one overlay colour, and one edge later swaps to a conflicting dim-only request with a different colour. Random stimulus then changes all controller bits at every edge, so inputs at the non-capture edges are exercised throughout the run.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

    // One controller sample: colour-select bits plus the two mode bits.
    typedef struct packed {
        logic red;
        logic grn;
        logic blu;
        logic ovl;
        logic dim;
    } osd_sample_t;

    // Channel ordering used for packed pixel arrays throughout the block.
    localparam int CH_RED = 2;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 0;
    localparam int NUM_CH = 3;

endpackage

// File: rtl/osd_sampler.sv
module osd_sampler
    import osd_mix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  osd_sample_t osd_i,
    output logic        half_clk_o,
    output osd_sample_t sample_o
);

    typedef struct packed {
        logic        phase;
        osd_sample_t smp;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        // Capture on the edge that raises the half-rate clock.
        if (!st_q.phase) begin
            st_d.smp = osd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_clk_o = st_q.phase;
    assign sample_o   = st_q.smp;

endmodule

// File: rtl/osd_palette.sv
module osd_palette
    import osd_mix_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  osd_sample_t                    sel_i,
    output logic [NUM_CH-1:0][PIX_W-1:0]   rgb_o
);

    // Colour-bar levels at three quarters and one quarter of full scale.
    localparam logic [PIX_W-1:0] LVL_HI = PIX_W'((3 << (PIX_W - 2)) - 1);
    localparam logic [PIX_W-1:0] LVL_LO = PIX_W'(1 << (PIX_W - 2));

    logic [NUM_CH-1:0] bits;

    always_comb begin
        bits         = '0;
        bits[CH_RED] = sel_i.red;
        bits[CH_GRN] = sel_i.grn;
        bits[CH_BLU] = sel_i.blu;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign rgb_o[c] = bits[c] ? LVL_HI : LVL_LO;
    end

endmodule

// File: rtl/mix_pipe.sv
module mix_pipe
    import osd_mix_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0][PIX_W-1:0] vid_i,
    input  logic                         hs_i,
    input  logic                         vs_i,
    input  osd_sample_t                  sample_i,
    input  logic [NUM_CH-1:0][PIX_W-1:0] pal_i,
    output logic [NUM_CH-1:0][PIX_W-1:0] pix_o,
    output logic                         hs_o,
    output logic                         vs_o,
    output logic                         ctl_hs_o,
    output logic                         ctl_vs_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][PIX_W-1:0] vid1;
        logic                         hs1;
        logic                         vs1;
        logic [NUM_CH-1:0][PIX_W-1:0] pix2;
        logic                         hs2;
        logic                         vs2;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vid1 = vid_i;
        st_d.hs1  = hs_i;
        st_d.vs1  = vs_i;
        st_d.hs2  = st_q.hs1;
        st_d.vs2  = st_q.vs1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sample_i.ovl) begin
                st_d.pix2[c] = pal_i[c];
            end else if (sample_i.dim) begin
                st_d.pix2[c] = st_q.vid1[c] >> 1;
            end else begin
                st_d.pix2[c] = st_q.vid1[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o    = st_q.pix2;
    assign hs_o     = st_q.hs2;
    assign vs_o     = st_q.vs2;
    assign ctl_hs_o = st_q.hs1;
    assign ctl_vs_o = st_q.vs1;

endmodule

// File: rtl/osd_video_mixer.sv
module osd_video_mixer
    import osd_mix_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] vid_red,
    input  logic [PIX_W-1:0] vid_grn,
    input  logic [PIX_W-1:0] vid_blu,
    input  logic             vid_hsync,
    input  logic             vid_vsync,
    input  logic             osd_red,
    input  logic             osd_grn,
    input  logic             osd_blu,
    input  logic             osd_ovl,
    input  logic             osd_dim,
    output logic [PIX_W-1:0] out_red,
    output logic [PIX_W-1:0] out_grn,
    output logic [PIX_W-1:0] out_blu,
    output logic             out_hsync,
    output logic             out_vsync,
    output logic             ctl_hsync,
    output logic             ctl_vsync,
    output logic             ctl_clk
);

    osd_sample_t                  osd_in;
    osd_sample_t                  cap_w;
    logic [NUM_CH-1:0][PIX_W-1:0] vid_w;
    logic [NUM_CH-1:0][PIX_W-1:0] pal_w;
    logic [NUM_CH-1:0][PIX_W-1:0] pix_w;

    assign osd_in = '{red: osd_red, grn: osd_grn, blu: osd_blu,
                      ovl: osd_ovl, dim: osd_dim};

    always_comb begin
        vid_w         = '0;
        vid_w[CH_RED] = vid_red;
        vid_w[CH_GRN] = vid_grn;
        vid_w[CH_BLU] = vid_blu;
    end

    osd_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .osd_i      (osd_in),
        .half_clk_o (ctl_clk),
        .sample_o   (cap_w)
    );

    osd_palette #(.PIX_W(PIX_W)) u_palette (
        .sel_i (cap_w),
        .rgb_o (pal_w)
    );

    mix_pipe #(.PIX_W(PIX_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_i    (vid_w),
        .hs_i     (vid_hsync),
        .vs_i     (vid_vsync),
        .sample_i (cap_w),
        .pal_i    (pal_w),
        .pix_o    (pix_w),
        .hs_o     (out_hsync),
        .vs_o     (out_vsync),
        .ctl_hs_o (ctl_hsync),
        .ctl_vs_o (ctl_vsync)
    );

    assign out_red = pix_w[CH_RED];
    assign out_grn = pix_w[CH_GRN];
    assign out_blu = pix_w[CH_BLU];

endmodule

// File: rtl/osd_video_mixer_chk.sv
module osd_video_mixer_chk
    import osd_mix_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIX_W-1:0] out_red,
    input logic [PIX_W-1:0] out_grn,
    input logic [PIX_W-1:0] out_blu,
    input logic             out_hsync,
    input logic             vid_hsync,
    input logic             vid_vsync,
    input logic             ctl_hsync,
    input logic             ctl_vsync,
    input logic             ctl_clk,
    input osd_sample_t      cap
);

    localparam logic [PIX_W-1:0] HI = PIX_W'((3 << (PIX_W - 2)) - 1);
    localparam logic [PIX_W-1:0] LO = PIX_W'(1 << (PIX_W - 2));

    // R2: half-rate clock alternates on every edge
    a_r2_half_clock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ctl_clk != $past(ctl_clk)));

    // R3: captured sample only moves on the rising half-clock edge
    a_r3_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ctl_clk) |-> $stable(cap));

    // R5: overlay drives fixed colour-bar levels
    a_r5_overlay_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap.ovl)) |->
        (out_red == ($past(cap.red) ? HI : LO)) &&
        (out_grn == ($past(cap.grn) ? HI : LO)) &&
        (out_blu == ($past(cap.blu) ? HI : LO)));

    // R6: dimmed background never reaches the top half of the range
    a_r6_dim_halves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap.dim && !cap.ovl)) |->
        (!out_red[PIX_W-1] && !out_grn[PIX_W-1] && !out_blu[PIX_W-1]));

    // R7: overlay keeps full level even when dim is requested
    a_r7_overlay_beats_dim: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap.ovl && cap.dim && cap.red)) |-> (out_red == HI));

    // R8: controller sync is one edge behind the video sync
    a_r8_ctl_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ctl_hsync == $past(vid_hsync)) && (ctl_vsync == $past(vid_vsync))));

    // R4: output sync is two edges behind the video sync
    a_r4_out_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_hsync == $past(vid_hsync, 2)));

endmodule

bind osd_video_mixer osd_video_mixer_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_red   (out_red),
    .out_grn   (out_grn),
    .out_blu   (out_blu),
    .out_hsync (out_hsync),
    .vid_hsync (vid_hsync),
    .vid_vsync (vid_vsync),
    .ctl_hsync (ctl_hsync),
    .ctl_vsync (ctl_vsync),
    .ctl_clk   (ctl_clk),
    .cap       (cap_w)
);

// File: tb/osd_video_mixer_test.sv
module osd_video_mixer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] vr, vg, vb;
    logic       hs, vs, o_r, o_g, o_b, o_ov, o_dm;
    logic [7:0] out_red, out_grn, out_blu;
    logic       out_hsync, out_vsync, ctl_hsync, ctl_vsync, ctl_clk;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic       m_ph;
    logic       mc_r, mc_g, mc_b, mc_o, mc_d;
    logic [7:0] mr, mg, mb;
    logic       m_hs1, m_vs1;

    always #2 clk = ~clk;

    osd_video_mixer uut (
        .clk(clk), .rst_n(rst_n),
        .vid_red(vr), .vid_grn(vg), .vid_blu(vb),
        .vid_hsync(hs), .vid_vsync(vs),
        .osd_red(o_r), .osd_grn(o_g), .osd_blu(o_b),
        .osd_ovl(o_ov), .osd_dim(o_dm),
        .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
        .out_hsync(out_hsync), .out_vsync(out_vsync),
        .ctl_hsync(ctl_hsync), .ctl_vsync(ctl_vsync), .ctl_clk(ctl_clk)
    );

    function automatic logic [7:0] bar_level(logic b);
        return b ? 8'hBF : 8'h40;
    endfunction

    function automatic logic [7:0] exp_chan(logic ov, logic dm, logic b, logic [7:0] v);
        if (ov) return bar_level(b);
        if (dm) return {1'b0, v[7:1]};
        return v;
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; mc_r = 0; mc_g = 0; mc_b = 0; mc_o = 0; mc_d = 0;
        mr = 0; mg = 0; mb = 0; m_hs1 = 0; m_vs1 = 0;
    endtask

    // One clock: inputs are already set; check outputs after the edge.
    task automatic cycle(string force_tag);
        string      tag;
        logic [7:0] er, eg, eb;
        logic       ehs, evs;
        @(posedge clk);
        if (force_tag != "") tag = force_tag;
        else if (mc_o && mc_d) tag = "R7";
        else if (mc_o) tag = "R5";
        else if (mc_d) tag = "R6";
        else tag = "R4";
        er = exp_chan(mc_o, mc_d, mc_r, mr);
        eg = exp_chan(mc_o, mc_d, mc_g, mg);
        eb = exp_chan(mc_o, mc_d, mc_b, mb);
        ehs = m_hs1; evs = m_vs1;
        m_hs1 = hs; m_vs1 = vs;
        mr = vr; mg = vg; mb = vb;
        if (!m_ph) begin
            mc_r = o_r; mc_g = o_g; mc_b = o_b; mc_o = o_ov; mc_d = o_dm;
        end
        m_ph = !m_ph;
        @(negedge clk);
        cmp(tag, "out_red", 32'(out_red), 32'(er));
        cmp(tag, "out_grn", 32'(out_grn), 32'(eg));
        cmp(tag, "out_blu", 32'(out_blu), 32'(eb));
        cmp("R4", "out_sync", {30'd0, out_hsync, out_vsync}, {30'd0, ehs, evs});
        cmp("R8", "ctl_sync", {30'd0, ctl_hsync, ctl_vsync}, {30'd0, m_hs1, m_vs1});
        cmp("R2", "ctl_clk", 32'(ctl_clk), 32'(m_ph));
    endtask

    task automatic set_osd(logic [2:0] col, logic ov, logic dm);
        {o_r, o_g, o_b} = col; o_ov = ov; o_dm = dm;
    endtask

    task automatic rand_video();
        vr = 8'($urandom); vg = 8'($urandom); vb = 8'($urandom);
        hs = 1'($urandom); vs = 1'($urandom);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        rst_n = 1'b0;
        vr = 8'hAA; vg = 8'h55; vb = 8'hFF; hs = 1; vs = 1;
        set_osd(3'b111, 1'b1, 1'b1);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state with active inputs
        cmp("R1", "out_rgb", {8'd0, out_red, out_grn, out_blu}, 32'd0);
        cmp("R1", "syncs", {28'd0, out_hsync, out_vsync, ctl_hsync, ctl_vsync}, 32'd0);
        cmp("R1", "ctl_clk", 32'(ctl_clk), 32'd0);
        rst_n = 1'b1;

        // R5: all eight colours
        for (int c = 0; c < 8; c++) begin
            set_osd(3'(c), 1'b1, 1'b0);
            rand_video(); cycle("");
            rand_video(); cycle("");
        end
        // R7: overlay with dim
        for (int c = 0; c < 8; c++) begin
            set_osd(3'(c), 1'b1, 1'b1);
            rand_video(); cycle("");
            rand_video(); cycle("");
        end
        // R6: dim-only boundaries
        set_osd(3'b010, 1'b0, 1'b1);
        vr = 8'hFF; vg = 8'h01; vb = 8'h80; cycle("");
        vr = 8'h00; vg = 8'hFE; vb = 8'h7F; cycle("");
        vr = 8'hFF; vg = 8'h01; vb = 8'h02; cycle("");
        vr = 8'h03; vg = 8'hFF; vb = 8'h00; cycle("");
        // R4: plain pass-through
        set_osd(3'b101, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            rand_video(); cycle("");
        end
        // R3: input change between capture edges must be ignored
        if (m_ph) begin rand_video(); cycle(""); end
        set_osd(3'b101, 1'b1, 1'b0);
        rand_video(); cycle("");
        set_osd(3'b010, 1'b0, 1'b1);
        rand_video(); cycle("R3");
        rand_video(); cycle("R3");
        set_osd(3'b000, 1'b0, 1'b0);
        rand_video(); cycle("R3");
        rand_video(); cycle("R3");

        // Random mix: every input may change at every edge
        for (int i = 0; i < 4000; i++) begin
            rand_video();
            set_osd(3'($urandom), 1'($urandom), 1'($urandom));
            cycle("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule